// File: doc/BRIEF.md
# Occupancy-Driven Clock Frequency Selector

This block decides which of a fixed set of pre-generated clocks should drive a packet classification engine. It derives the fill level of the header buffer in front of that engine from the buffer's write and read pointers. From that level it picks a frequency-select index. A low index means a slow clock and a high index means a fast one. Index `i` stands for `Fmax / 2^(NSTATE-1-i)`, so each step up doubles the clock rate.

Each state has a programmable threshold register, and a programmable mask marks which states may be used at all.

- **Going faster:** while the fill level is above the current state's threshold, the selector climbs to the next used state above it.
- **Going slower:** it drops back only when the buffer is completely empty, and then it goes straight to the lowest used state.

Every change of the select is preceded by a handshake. The selector raises `idle_req`, waits for `idle_ack` from the engine, and only then moves `freq_sel` and releases the request. The clock generators and the glitch-free clock multiplexer sit outside this block.

Top module: `occ_freq_sel`

## Requirements
- R1: After reset `freq_sel` is 0, `idle_req` is low, every state is marked used, and threshold `i` is `(i+1)*2^PTR_W/NSTATE` with integer division.
- R2: Occupancy is `wr_ptr - rd_ptr` taken modulo `2^(PTR_W+1)`, so a write pointer that has wrapped below the read pointer still gives the right level.
- R3: With no handshake pending, suppose occupancy is strictly greater than the threshold of the current state and some used state lies above it. The selector then raises `idle_req` and targets the nearest used state above, skipping unused states.
- R4: With no handshake pending, suppose occupancy is zero and the current state is not the lowest used state. The selector then raises `idle_req` and targets the lowest used state directly. If the mask is all zero, the lowest used state is taken as 0.
- R5: With no handshake pending, suppose occupancy is non-zero and not above the current threshold. Then no request is made: the frequency never steps down one state at a time.
- R6: When no used state lies above the current one, no upward request is made, whatever its threshold register holds.
- R7: `idle_req` appears one cycle after the decision and stays high until `idle_ack` is sampled high. On that clock edge `freq_sel` takes the target and `idle_req` falls. `freq_sel` changes at no other time.
- R8: The target is fixed when the request is raised. Input changes during the handshake do not alter it. A new decision is made only after the request is released.
- R9: When `thr_we` is high, `thr_val` is written to the threshold of state `thr_idx`, and an index of `NSTATE` or more is ignored. When `mask_we` is high, `mask_val` replaces the used mask, where bit `i` set means state `i` is used. Both writes take effect from the next cycle.
- R10: When exactly one state is used and the selector is in it, no request is ever raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_ptr | input | PTR_W+1 | Header buffer write pointer, with wrap bit |
| rd_ptr | input | PTR_W+1 | Header buffer read pointer, with wrap bit |
| thr_we | input | 1 | Threshold write strobe |
| thr_idx | input | $clog2(NSTATE) | State whose threshold is written |
| thr_val | input | PTR_W+1 | Threshold value to write |
| mask_we | input | 1 | Used-mask write strobe |
| mask_val | input | NSTATE | New used mask, bit i for state i |
| idle_ack | input | 1 | Engine reports it is idle |
| idle_req | output | 1 | Request for the engine to go idle before a switch |
| freq_sel | output | $clog2(NSTATE) | Selected frequency index |

## Verification
A wrong current state, target or mask in this block shows up at `freq_sel` or `idle_req` within one handshake.

- A wrong current state shows within one clock, as a request that should not be there or one that is missing.
- A wrong target shows on the edge where `idle_ack` is accepted.
- A stale threshold or mask shows when the level next crosses it, or when the buffer next drains to empty.

Because of this, a behavioural reference model compared on every clock catches such faults. The comparison covers ramps, drains, pointer wrap, sparse masks, a single-state mask and long acknowledge delays.

// File: rtl/occ_freq_sel.sv
module occ_freq_sel #(
  parameter int NSTATE = 10,
  parameter int PTR_W = 6,
  localparam int IDX_W = $clog2(NSTATE),
  localparam int OCC_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OCC_W-1:0] wr_ptr,
  input  logic [OCC_W-1:0] rd_ptr,
  input  logic             thr_we,
  input  logic [IDX_W-1:0] thr_idx,
  input  logic [OCC_W-1:0] thr_val,
  input  logic             mask_we,
  input  logic [NSTATE-1:0] mask_val,
  input  logic             idle_ack,
  output logic             idle_req,
  output logic [IDX_W-1:0] freq_sel
);

  localparam int DEPTH = 1 << PTR_W;

  logic [OCC_W-1:0]  thr_q [NSTATE];
  logic [NSTATE-1:0] used_q;
  logic [IDX_W-1:0]  cur_q, tgt_q, low_idx, up_idx;
  logic              busy_q, has_up, go_up, go_low;
  logic [OCC_W-1:0]  occ, cur_thr;

  assign occ = wr_ptr - rd_ptr;

  always_comb begin
    low_idx = '0;
    up_idx  = cur_q;
    has_up  = 1'b0;
    cur_thr = '0;
    for (int i = NSTATE - 1; i >= 0; i--) begin
      if (used_q[i]) low_idx = IDX_W'(i);
      if (used_q[i] && i > int'(cur_q)) begin
        up_idx = IDX_W'(i);
        has_up = 1'b1;
      end
      if (int'(cur_q) == i) cur_thr = thr_q[i];
    end
  end

  assign go_low = (occ == '0) && (cur_q != low_idx);
  assign go_up  = has_up && (occ > cur_thr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      tgt_q  <= '0;
      used_q <= '1;
      for (int i = 0; i < NSTATE; i++)
        thr_q[i] <= OCC_W'(((i + 1) * DEPTH) / NSTATE);
    end else begin
      if (busy_q) begin
        if (idle_ack) begin
          cur_q  <= tgt_q;
          busy_q <= 1'b0;
        end
      end else if (go_low) begin
        busy_q <= 1'b1;
        tgt_q  <= low_idx;
      end else if (go_up) begin
        busy_q <= 1'b1;
        tgt_q  <= up_idx;
      end
      if (thr_we && int'(thr_idx) < NSTATE) thr_q[thr_idx] <= thr_val;
      if (mask_we) used_q <= mask_val;
    end
  end

  assign idle_req = busy_q;
  assign freq_sel = cur_q;

  p_sel_moves_on_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(freq_sel) |-> $past(idle_req && idle_ack));

  p_req_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    idle_req && !idle_ack |=> idle_req);

  p_req_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    idle_req && idle_ack |=> !idle_req && freq_sel == $past(tgt_q));

  p_target_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    idle_req && !idle_ack |=> $stable(tgt_q));

  p_empty_to_lowest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_req && occ == '0 && freq_sel != low_idx |=> idle_req && tgt_q == $past(low_idx));

  p_no_step_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_req && occ != '0 && occ <= cur_thr |=> !idle_req);

  p_top_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_req && occ != '0 && !has_up |=> !idle_req);

  p_single_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_req && $countones(used_q) == 1 && freq_sel == low_idx |=> !idle_req);

endmodule

// File: tb/sim_occ_freq_sel.sv
module sim_occ_freq_sel;
  localparam int N = 10;
  localparam int PW = 6;
  localparam int MOD = 128;

  logic clk = 0, rst_n = 0;
  logic [6:0] wr_ptr = 0, rd_ptr = 0, thr_val = 0;
  logic thr_we = 0, mask_we = 0, idle_ack = 0;
  logic [3:0] thr_idx = 0;
  logic [9:0] mask_val = 0;
  logic idle_req;
  logic [3:0] freq_sel;

  occ_freq_sel #(.NSTATE(N), .PTR_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .thr_we(thr_we), .thr_idx(thr_idx), .thr_val(thr_val),
    .mask_we(mask_we), .mask_val(mask_val), .idle_ack(idle_ack),
    .idle_req(idle_req), .freq_sel(freq_sel));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  int m_thr[N];
  bit [9:0] m_used;
  int m_cur, m_tgt;
  bit m_busy;
  int ack_dly = 1, ack_cnt = 0, base = 0;
  string req = "R1";

  task automatic chk(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    int occ, low, up, n_cur, n_tgt;
    bit n_busy;
    occ = int'(wr_ptr) - int'(rd_ptr);
    if (occ < 0) occ += MOD;
    low = 0;
    up = -1;
    for (int i = N - 1; i >= 0; i--) begin
      if (m_used[i]) low = i;
      if (m_used[i] && i > m_cur) up = i;
    end
    n_cur = m_cur; n_tgt = m_tgt; n_busy = m_busy;
    if (m_busy) begin
      if (idle_ack) begin n_cur = m_tgt; n_busy = 0; end
    end else if (occ == 0 && m_cur != low) begin
      n_busy = 1; n_tgt = low;
    end else if (up >= 0 && occ > m_thr[m_cur]) begin
      n_busy = 1; n_tgt = up;
    end
    @(posedge clk);
    @(negedge clk);
    if (!rst_n) begin
      m_cur = 0; m_tgt = 0; m_busy = 0; m_used = '1;
      for (int i = 0; i < N; i++) m_thr[i] = ((i + 1) * 64) / N;
    end else begin
      m_cur = n_cur; m_tgt = n_tgt; m_busy = n_busy;
      if (thr_we && thr_idx < N) m_thr[thr_idx] = int'(thr_val);
      if (mask_we) m_used = mask_val;
    end
    chk(int'(freq_sel), m_cur, req);
    chk(int'(idle_req), int'(m_busy), req);
    thr_we = 0;
    mask_we = 0;
    if (idle_req) ack_cnt++; else ack_cnt = 0;
    idle_ack = idle_req && (ack_cnt > ack_dly);
  endtask

  task automatic set_ptr(int b, int lvl);
    base = b % MOD;
    rd_ptr = 7'(base);
    wr_ptr = 7'((base + lvl) % MOD);
  endtask

  task automatic set_lvl(int lvl);
    set_ptr(base + 37, lvl);
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic wr_mask(bit [9:0] m);
    mask_val = m;
    mask_we = 1;
    step();
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit seen;
    req = "R1";
    run(3);
    rst_n = 1;
    step();
    chk(int'(freq_sel), 0, "R1");
    chk(int'(idle_req), 0, "R1");

    req = "R3";
    for (int l = 0; l <= 64; l++) begin
      set_lvl(l);
      run(3);
    end
    run(20);
    chk(int'(freq_sel), 9, "R3");

    req = "R5";
    for (int l = 64; l > 0; l -= 3) begin
      set_lvl(l);
      run(2);
    end
    chk(int'(freq_sel), 9, "R5");

    req = "R4";
    set_lvl(0);
    run(6);
    chk(int'(freq_sel), 0, "R4");

    req = "R3";
    wr_mask(10'b1110010000);
    run(8);
    chk(int'(freq_sel), 4, "R4");
    set_lvl(33);
    run(8);
    chk(int'(freq_sel), 7, "R3");

    req = "R6";
    thr_idx = 9;
    thr_val = 1;
    thr_we = 1;
    step();
    set_lvl(64);
    run(20);
    chk(int'(freq_sel), 9, "R6");
    chk(int'(idle_req), 0, "R6");

    req = "R8";
    wr_mask('1);
    ack_dly = 15;
    set_lvl(0);
    run(3);
    set_lvl(60);
    for (int k = 0; k < 40 && idle_req; k++) step();
    chk(int'(freq_sel), 0, "R8");
    ack_dly = 1;
    run(10);

    req = "R10";
    set_lvl(0);
    wr_mask(10'b0000100000);
    run(8);
    chk(int'(freq_sel), 5, "R10");
    seen = 0;
    for (int k = 0; k < 200; k++) begin
      set_lvl(int'($urandom_range(0, 64)));
      step();
      if (idle_req) seen = 1;
    end
    chk(int'(seen), 0, "R10");
    chk(int'(freq_sel), 5, "R10");

    req = "R2";
    wr_mask('1);
    set_lvl(0);
    run(6);
    set_ptr(120, 7);
    run(6);
    chk(int'(freq_sel), 1, "R2");

    req = "R9";
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(0, 7) == 0) begin
        thr_idx = 4'($urandom_range(0, 11));
        thr_val = 7'($urandom_range(0, 64));
        thr_we = 1;
      end
      if ($urandom_range(0, 99) == 0) begin
        mask_val = 10'($urandom);
        mask_we = 1;
      end
      if ($urandom_range(0, 3) == 0)
        set_lvl($urandom_range(0, 3) == 0 ? 0 : int'($urandom_range(0, 64)));
      if ($urandom_range(0, 49) == 0) ack_dly = int'($urandom_range(0, 4));
      step();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule